// File: doc/BRIEF.md
# DMA Channel Controller with Peripheral Handshake

This block runs a single DMA channel between a peripheral and a simplified bus master. Software sets a source address, a destination address, item widths, a block size and two mode flags through a small register port. It then starts the channel with an enable command and stops it with a separate disable command. A status output reports whether the channel is live.

Once the channel is live, the peripheral asks for data movement with a single request (one item) or a burst request (up to four items). It can mark a request as the last of the block. The controller issues one bus beat per item, advancing the source and destination pointers by the programmed widths. It answers each request with a one-cycle acknowledge after the final beat. A block ends when the internal item counter runs out, or, when the peripheral controls the flow, when a request carrying the last flag has been served. With auto-reload set, the counter refills after each block and the channel stays live.

A disable request never cuts a transfer short: the channel finishes the beats it already owes, and only then drops its status. Configuration is frozen while the channel is live.

Top module: `dma_chan_ctrl`

## Requirements
- R1: After a synchronous reset, en_status, err, done, ack, bus_valid and bus_last are 0, and all configuration registers hold 0.
- R2: While en_status is 1, every configuration write is ignored: the bus addresses keep following the values captured at start. A write made while en_status is 0 takes effect at the next start.
- R3: A disable command leaves en_status at 1 until the final beat of the transfer in progress has been accepted. en_status then falls on the same edge that raises ack. A disable command given while no transfer is in progress drops en_status on the next clock edge. bus_valid is never 1 while en_status is 0.
- R4: With the controller as flow master (mode bit 5 = 0) and a block size of 0, an enable command leaves en_status at 0 and no done pulse appears.
- R5: Width codes are 0 = byte, 1 = half-word, 2 = word, 3 = illegal. An enable command whose source or destination address is misaligned for its width sets err to 1, and the channel stays disabled. Misaligned means bit 0 set for half-word, either of bits 1:0 set for word, or any address with code 3. err is recomputed at every enable command.
- R6: A single request produces exactly one bus beat. A burst request produces 4 beats, or fewer when the controller is flow master and fewer items remain. ack is a one-cycle pulse in the cycle after the final beat is accepted.
- R7: On each accepted beat, the source address advances by 1, 2 or 4 bytes per its width, and the destination address advances by its own width.
- R8: With the controller as flow master, the beat that brings the remaining count to zero ends the block. done pulses for one cycle together with ack, and en_status clears unless auto-reload is set.
- R9: With auto-reload (mode bit 4 = 1), the remaining count refills from the programmed size at the end of each block, and en_status stays at 1.
- R10: With the peripheral as flow master (mode bit 5 = 1), a request carrying req_last ends the block after its beats: done pulses and en_status clears. This holds even when that request is the first one after enabling.
- R11: Requests presented while the channel is disabled produce no bus beat and no ack.
- R12: Register select codes: 0 = source address, 1 = destination address, 2 = block size, 3 = mode (bits 1:0 source width, bits 3:2 destination width, bit 4 auto-reload, bit 5 peripheral flow control).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration register select |
| cfg_wdata | input | 32 | Configuration write data |
| en_cmd | input | 1 | Enable command pulse |
| dis_cmd | input | 1 | Disable command pulse |
| en_status | output | 1 | Channel live status |
| err | output | 1 | Alignment error from the last enable command |
| done | output | 1 | One-cycle block completion pulse |
| req_single | input | 1 | Peripheral single-item request |
| req_burst | input | 1 | Peripheral burst request |
| req_last | input | 1 | Request is the last of the block |
| ack | output | 1 | One-cycle acknowledge to the peripheral |
| bus_valid | output | 1 | Bus beat valid |
| bus_ready | input | 1 | Bus accepts the beat |
| bus_src | output | 32 | Source address of the current beat |
| bus_dst | output | 32 | Destination address of the current beat |
| bus_last | output | 1 | Final beat of the current transfer |

## Verification
The bench targets a disable that arrives in the middle of a burst. A design that drops status at once would cut the burst short and never acknowledge it. It also writes configuration while the channel is live; a design without the lock would show the new source address on the next beat. Bursts that straddle the end of a block must shrink to the remaining count; getting this wrong overruns the block by up to three items. Further directed cases cover a zero-size start, misaligned addresses and the illegal width code, auto-reload across two blocks, and a peripheral-flow block whose very first request is also its last. Each of these fails visibly through beat counts, done, or en_status.

// File: rtl/dmach_pkg.sv
package dmach_pkg;

  typedef enum logic [1:0] {
    W_BYTE = 2'd0,
    W_HALF = 2'd1,
    W_WORD = 2'd2,
    W_BAD  = 2'd3
  } wid_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_XFER,
    ST_GAP
  } st_e;

  localparam logic [1:0] SEL_SRC  = 2'd0;
  localparam logic [1:0] SEL_DST  = 2'd1;
  localparam logic [1:0] SEL_SIZE = 2'd2;
  localparam logic [1:0] SEL_MODE = 2'd3;

  function automatic logic bad_align(input logic [1:0] wid, input logic [1:0] lsb);
    case (wid)
      W_HALF:  return lsb[0];
      W_WORD:  return |lsb;
      W_BAD:   return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/dmach_cfg.sv
module dmach_cfg
  import dmach_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [1:0]        sel,
  input  logic [DATA_W-1:0] wdata,
  input  logic              lock,
  output logic [ADDR_W-1:0] src_base,
  output logic [ADDR_W-1:0] dst_base,
  output logic [SIZE_W-1:0] blk_size,
  output logic [1:0]        src_wid,
  output logic [1:0]        dst_wid,
  output logic              auto_rl,
  output logic              pflow,
  output logic              misalign
);

  logic [5:0] mode_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      src_base <= '0;
      dst_base <= '0;
      blk_size <= '0;
      mode_q   <= '0;
    end else if (we && !lock) begin
      case (sel)
        SEL_SRC:  src_base <= wdata[ADDR_W-1:0];
        SEL_DST:  dst_base <= wdata[ADDR_W-1:0];
        SEL_SIZE: blk_size <= wdata[SIZE_W-1:0];
        default:  mode_q   <= wdata[5:0];
      endcase
    end
  end

  assign src_wid = mode_q[1:0];
  assign dst_wid = mode_q[3:2];
  assign auto_rl = mode_q[4];
  assign pflow   = mode_q[5];

  assign misalign = bad_align(src_wid, src_base[1:0]) | bad_align(dst_wid, dst_base[1:0]);

endmodule

// File: rtl/dmach_addr.sv
module dmach_addr #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              step,
  input  logic [ADDR_W-1:0] base,
  input  logic [1:0]        wid,
  output logic [ADDR_W-1:0] addr
);

  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  logic [ADDR_W-1:0] inc;
  assign inc = ONE << wid;

  always_ff @(posedge clk) begin
    if (rst)       addr <= '0;
    else if (load) addr <= base;
    else if (step) addr <= addr + inc;
  end

endmodule

// File: rtl/dmach_fsm.sv
module dmach_fsm
  import dmach_pkg::*;
#(
  parameter int SIZE_W = 12,
  parameter int BURST  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_cmd,
  input  logic              dis_cmd,
  input  logic              req_single,
  input  logic              req_burst,
  input  logic              req_last,
  input  logic              bus_ready,
  input  logic [SIZE_W-1:0] blk_size,
  input  logic              auto_rl,
  input  logic              pflow,
  input  logic              misalign,
  output logic              en_status,
  output logic              err,
  output logic              done,
  output logic              ack,
  output logic              bus_valid,
  output logic              bus_last,
  output logic              start,
  output logic              step
);

  localparam int BEAT_W = $clog2(BURST + 1);
  localparam logic [BEAT_W-1:0] BURST_N = BEAT_W'(BURST);
  localparam logic [SIZE_W-1:0] BURST_S = SIZE_W'(BURST);

  st_e               state;
  logic [SIZE_W-1:0] rem;
  logic [BEAT_W-1:0] beats;
  logic              last_q;
  logic              dis_pend;
  logic [BEAT_W-1:0] n_beats;
  logic              blk_end;
  logic              stop;
  logic              quit;

  assign start = (state == ST_IDLE) && en_cmd && !misalign && (pflow || (blk_size != '0));
  assign step  = (state == ST_XFER) && bus_valid && bus_ready;
  assign quit  = dis_cmd || dis_pend;

  always_comb begin
    n_beats = BEAT_W'(1);
    if (req_burst) begin
      if (!pflow && (rem < BURST_S)) n_beats = rem[BEAT_W-1:0];
      else                           n_beats = BURST_N;
    end
  end

  assign blk_end = pflow ? last_q : (rem == SIZE_W'(1));
  assign stop    = quit || (blk_end && !auto_rl);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      en_status <= 1'b0;
      err       <= 1'b0;
      done      <= 1'b0;
      ack       <= 1'b0;
      bus_valid <= 1'b0;
      bus_last  <= 1'b0;
      rem       <= '0;
      beats     <= '0;
      last_q    <= 1'b0;
      dis_pend  <= 1'b0;
    end else begin
      done <= 1'b0;
      ack  <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (en_cmd) begin
            err <= misalign;
            if (start) begin
              en_status <= 1'b1;
              rem       <= blk_size;
              state     <= ST_WAIT;
            end
          end
        end
        ST_WAIT: begin
          if (quit) begin
            en_status <= 1'b0;
            dis_pend  <= 1'b0;
            state     <= ST_IDLE;
          end else if (req_single || req_burst) begin
            beats     <= n_beats;
            last_q    <= req_last;
            bus_valid <= 1'b1;
            bus_last  <= (n_beats == BEAT_W'(1));
            state     <= ST_XFER;
          end
        end
        ST_XFER: begin
          if (dis_cmd) dis_pend <= 1'b1;
          if (bus_ready) begin
            if (!pflow) rem <= rem - SIZE_W'(1);
            beats    <= beats - BEAT_W'(1);
            bus_last <= (beats == BEAT_W'(2));
            if (beats == BEAT_W'(1)) begin
              bus_valid <= 1'b0;
              bus_last  <= 1'b0;
              ack       <= 1'b1;
              done      <= blk_end;
              if (blk_end && auto_rl && !pflow) rem <= blk_size;
              if (stop) begin
                en_status <= 1'b0;
                dis_pend  <= 1'b0;
                state     <= ST_IDLE;
              end else begin
                state <= ST_GAP;
              end
            end
          end
        end
        default: begin
          if (quit) begin
            en_status <= 1'b0;
            dis_pend  <= 1'b0;
            state     <= ST_IDLE;
          end else begin
            state <= ST_WAIT;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 12,
  parameter int BURST  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              en_cmd,
  input  logic              dis_cmd,
  output logic              en_status,
  output logic              err,
  output logic              done,
  input  logic              req_single,
  input  logic              req_burst,
  input  logic              req_last,
  output logic              ack,
  output logic              bus_valid,
  input  logic              bus_ready,
  output logic [ADDR_W-1:0] bus_src,
  output logic [ADDR_W-1:0] bus_dst,
  output logic              bus_last
);

  localparam int NPTR = 2;

  logic [ADDR_W-1:0] cfg_src;
  logic [ADDR_W-1:0] cfg_dst;
  logic [SIZE_W-1:0] cfg_size;
  logic [1:0]        cfg_swid;
  logic [1:0]        cfg_dwid;
  logic              cfg_auto;
  logic              cfg_pflow;
  logic              cfg_misalign;
  logic              start;
  logic              step;

  logic [ADDR_W-1:0] base_a [NPTR];
  logic [1:0]        wid_a  [NPTR];
  logic [ADDR_W-1:0] addr_a [NPTR];

  dmach_cfg #(
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W),
    .SIZE_W(SIZE_W)
  ) u_cfg (
    .clk      (clk),
    .rst      (rst),
    .we       (cfg_we),
    .sel      (cfg_sel),
    .wdata    (cfg_wdata),
    .lock     (en_status),
    .src_base (cfg_src),
    .dst_base (cfg_dst),
    .blk_size (cfg_size),
    .src_wid  (cfg_swid),
    .dst_wid  (cfg_dwid),
    .auto_rl  (cfg_auto),
    .pflow    (cfg_pflow),
    .misalign (cfg_misalign)
  );

  assign base_a[0] = cfg_src;
  assign base_a[1] = cfg_dst;
  assign wid_a[0]  = cfg_swid;
  assign wid_a[1]  = cfg_dwid;

  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    dmach_addr #(
      .ADDR_W(ADDR_W)
    ) u_addr (
      .clk  (clk),
      .rst  (rst),
      .load (start),
      .step (step),
      .base (base_a[g]),
      .wid  (wid_a[g]),
      .addr (addr_a[g])
    );
  end

  assign bus_src = addr_a[0];
  assign bus_dst = addr_a[1];

  dmach_fsm #(
    .SIZE_W(SIZE_W),
    .BURST (BURST)
  ) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .en_cmd     (en_cmd),
    .dis_cmd    (dis_cmd),
    .req_single (req_single),
    .req_burst  (req_burst),
    .req_last   (req_last),
    .bus_ready  (bus_ready),
    .blk_size   (cfg_size),
    .auto_rl    (cfg_auto),
    .pflow      (cfg_pflow),
    .misalign   (cfg_misalign),
    .en_status  (en_status),
    .err        (err),
    .done       (done),
    .ack        (ack),
    .bus_valid  (bus_valid),
    .bus_last   (bus_last),
    .start      (start),
    .step       (step)
  );

endmodule

// File: rtl/dmach_chk.sv
module dmach_chk #(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              en_status,
  input logic              err,
  input logic              done,
  input logic              ack,
  input logic              bus_valid,
  input logic              bus_ready,
  input logic [ADDR_W-1:0] cfg_src,
  input logic [SIZE_W-1:0] cfg_size,
  input logic              cfg_pflow
);

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
    en_status |=> ($stable(cfg_src) && $stable(cfg_size))); // R2

  AST_BEAT_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    bus_valid |-> en_status); // R3

  AST_FALL_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    $fell(en_status) |-> !bus_valid); // R3

  AST_ZERO_SIZE_NO_START: assert property (@(posedge clk) disable iff (rst)
    $rose(en_status) |-> (cfg_pflow || (cfg_size != '0))); // R4

  AST_ERR_BLOCKS_START: assert property (@(posedge clk) disable iff (rst)
    err |-> !en_status); // R5

  AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack); // R6

  AST_ACK_AFTER_BEAT: assert property (@(posedge clk) disable iff (rst)
    $rose(ack) |-> $past(bus_valid && bus_ready)); // R6

  AST_DONE_WITH_ACK: assert property (@(posedge clk) disable iff (rst)
    done |-> ack); // R8

endmodule

bind dma_chan_ctrl dmach_chk #(
  .ADDR_W(ADDR_W),
  .SIZE_W(SIZE_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .en_status (en_status),
  .err       (err),
  .done      (done),
  .ack       (ack),
  .bus_valid (bus_valid),
  .bus_ready (bus_ready),
  .cfg_src   (cfg_src),
  .cfg_size  (cfg_size),
  .cfg_pflow (cfg_pflow)
);

// File: tb/tb_dma_chan_ctrl.sv
module tb_dma_chan_ctrl;
  import dmach_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        en_cmd = 1'b0;
  logic        dis_cmd = 1'b0;
  logic        en_status, err, done, ack, bus_valid, bus_last;
  logic        req_single = 1'b0;
  logic        req_burst = 1'b0;
  logic        req_last = 1'b0;
  logic        bus_ready = 1'b1;
  logic [31:0] bus_src, bus_dst;

  int nchk = 0;
  int nerr = 0;
  bit finished = 0;

  logic [31:0] exp_src, exp_dst;
  logic [1:0]  cur_sw, cur_dw;

  always #2.5 clk = ~clk;

  dma_chan_ctrl dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .en_cmd(en_cmd), .dis_cmd(dis_cmd), .en_status(en_status), .err(err), .done(done),
    .req_single(req_single), .req_burst(req_burst), .req_last(req_last), .ack(ack),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_src(bus_src), .bus_dst(bus_dst),
    .bus_last(bus_last)
  );

  typedef struct packed {
    logic [31:0] src;
    logic [31:0] dst;
    logic [1:0]  sw;
    logic [1:0]  dw;
    logic [11:0] size;
    logic        burst;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{32'h0000_0100, 32'h0000_0200, 2'd0, 2'd0, 12'd3, 1'b0},
    '{32'h0000_1000, 32'h0000_2002, 2'd2, 2'd1, 12'd5, 1'b0},
    '{32'h0000_0400, 32'h0000_0800, 2'd1, 2'd2, 12'd6, 1'b1},
    '{32'h0000_0010, 32'h0000_0020, 2'd2, 2'd2, 12'd8, 1'b1},
    '{32'h0000_0003, 32'h0000_0040, 2'd0, 2'd2, 12'd4, 1'b1},
    '{32'h0000_0006, 32'h0000_0009, 2'd1, 2'd0, 12'd7, 1'b1}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] sel, input logic [31:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic setup(input logic [31:0] s, input logic [31:0] d, input logic [11:0] sz,
                       input logic [1:0] sw, input logic [1:0] dw, input bit au, input bit pf);
    cfg_write(SEL_SRC, s);
    cfg_write(SEL_DST, d);
    cfg_write(SEL_SIZE, {20'd0, sz});
    cfg_write(SEL_MODE, {26'd0, pf, au, dw, sw});
    exp_src = s; exp_dst = d; cur_sw = sw; cur_dw = dw;
  endtask

  task automatic pulse_en();
    @(negedge clk); en_cmd = 1'b1;
    @(negedge clk); en_cmd = 1'b0;
  endtask

  task automatic pulse_dis();
    @(negedge clk); dis_cmd = 1'b1;
    @(negedge clk); dis_cmd = 1'b0;
  endtask

  // One request; counts beats, checks each beat's addresses (R7), returns state at ack.
  task automatic do_req(input bit burst, input bit last, output int beats,
                        output logic dn, output logic en_at);
    bit got = 0;
    @(negedge clk);
    req_single = !burst; req_burst = burst; req_last = last;
    beats = 0; dn = 1'b0; en_at = 1'b0;
    for (int k = 0; k < 40 && !got; k++) begin
      @(negedge clk);
      if (bus_valid && bus_ready) begin
        check("R7 src addr", bus_src, exp_src);
        check("R7 dst addr", bus_dst, exp_dst);
        exp_src = exp_src + (32'd1 << cur_sw);
        exp_dst = exp_dst + (32'd1 << cur_dw);
        beats++;
      end
      if (ack) begin
        got = 1; dn = done; en_at = en_status;
      end
    end
    req_single = 1'b0; req_burst = 1'b0; req_last = 1'b0;
    check("R6 ack seen", {31'd0, got}, 32'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nerr++; nchk++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    int beats;
    logic dn, ena;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 en_status", {31'd0, en_status}, 32'd0);
    check("R1 err", {31'd0, err}, 32'd0);
    check("R1 done", {31'd0, done}, 32'd0);
    check("R1 ack", {31'd0, ack}, 32'd0);
    check("R1 bus_valid", {31'd0, bus_valid}, 32'd0);
    check("R1 bus_last", {31'd0, bus_last}, 32'd0);
    // R1: configuration cleared: size 0 + controller flow means enable cannot start
    pulse_en();
    check("R1 cleared cfg no start", {31'd0, en_status}, 32'd0);

    // R11 requests while disabled
    req_burst = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R11 no beat", {31'd0, bus_valid}, 32'd0);
      check("R11 no ack", {31'd0, ack}, 32'd0);
    end
    req_burst = 1'b0;

    // Table walk: R6 R7 R8 R12
    for (int i = 0; i < NVEC; i++) begin
      automatic vec_t v = VECS[i];
      automatic int rem = v.size;
      automatic int eb;
      setup(v.src, v.dst, v.size, v.sw, v.dw, 1'b0, 1'b0);
      pulse_en();
      check("R12 en after start", {31'd0, en_status}, 32'd1);
      check("R5 err clear", {31'd0, err}, 32'd0);
      while (rem > 0) begin
        eb = v.burst ? ((rem < 4) ? rem : 4) : 1;
        do_req(v.burst, 1'b0, beats, dn, ena);
        check("R6 beats", beats, eb);
        rem -= eb;
        if (rem == 0) begin
          check("R8 done at end", {31'd0, dn}, 32'd1);
          check("R8 en cleared", {31'd0, ena}, 32'd0);
        end else begin
          check("R8 no done mid", {31'd0, dn}, 32'd0);
          check("R8 en held mid", {31'd0, ena}, 32'd1);
        end
      end
      @(negedge clk);
      check("R6 ack pulse one cycle", {31'd0, ack}, 32'd0);
    end

    // R4 zero size, controller flow
    setup(32'h40, 32'h80, 12'd0, 2'd0, 2'd0, 1'b0, 1'b0);
    pulse_en();
    check("R4 no start", {31'd0, en_status}, 32'd0);
    check("R4 no done", {31'd0, done}, 32'd0);
    check("R4 no err", {31'd0, err}, 32'd0);

    // R5 misalignment
    setup(32'h1001, 32'h80, 12'd4, 2'd1, 2'd0, 1'b0, 1'b0);
    pulse_en();
    check("R5 half misaligned err", {31'd0, err}, 32'd1);
    check("R5 half misaligned no start", {31'd0, en_status}, 32'd0);
    setup(32'h1000, 32'h82, 12'd4, 2'd0, 2'd2, 1'b0, 1'b0);
    pulse_en();
    check("R5 word misaligned err", {31'd0, err}, 32'd1);
    check("R5 word misaligned no start", {31'd0, en_status}, 32'd0);
    setup(32'h1000, 32'h80, 12'd4, 2'd3, 2'd0, 1'b0, 1'b0);
    pulse_en();
    check("R5 illegal width err", {31'd0, err}, 32'd1);
    setup(32'h1000, 32'h80, 12'd4, 2'd1, 2'd2, 1'b0, 1'b0);
    pulse_en();
    check("R5 aligned err clear", {31'd0, err}, 32'd0);
    check("R5 aligned start", {31'd0, en_status}, 32'd1);
    pulse_dis();
    check("R3 idle disable immediate", {31'd0, en_status}, 32'd0);

    // R2 configuration lock
    setup(32'h300, 32'h380, 12'd8, 2'd0, 2'd0, 1'b0, 1'b0);
    pulse_en();
    do_req(1'b0, 1'b0, beats, dn, ena);
    cfg_write(SEL_SRC, 32'h900);
    cfg_write(SEL_MODE, {26'd0, 1'b0, 1'b0, 2'd2, 2'd2});
    do_req(1'b0, 1'b0, beats, dn, ena);   // expects 0x301 / 0x381
    check("R2 write ignored, still live", {31'd0, ena}, 32'd1);
    pulse_dis();
    check("R3 disable in wait", {31'd0, en_status}, 32'd0);
    cfg_write(SEL_SRC, 32'h900);
    pulse_en();
    exp_src = 32'h900; exp_dst = 32'h380;
    do_req(1'b0, 1'b0, beats, dn, ena);   // R2 write while disabled took effect
    pulse_dis();

    // R3 disable in the middle of a burst
    setup(32'h1000, 32'h2000, 12'd16, 2'd2, 2'd2, 1'b0, 1'b0);
    pulse_en();
    @(negedge clk);
    req_burst = 1'b1;
    beats = 0;
    begin
      bit got = 0;
      for (int k = 0; k < 40 && !got; k++) begin
        @(negedge clk);
        dis_cmd = 1'b0;
        if (bus_valid) begin
          beats++;
          if (beats == 1) dis_cmd = 1'b1;
          if (beats == 2) check("R3 en held during burst", {31'd0, en_status}, 32'd1);
        end
        if (ack) begin
          got = 1;
          check("R3 en drops with ack", {31'd0, en_status}, 32'd0);
        end
      end
      req_burst = 1'b0;
      dis_cmd = 1'b0;
      check("R3 burst completed", beats, 4);
    end

    // R9 auto reload
    setup(32'h500, 32'h600, 12'd2, 2'd0, 2'd0, 1'b1, 1'b0);
    pulse_en();
    for (int blk = 0; blk < 2; blk++) begin
      do_req(1'b0, 1'b0, beats, dn, ena);
      check("R9 no done first item", {31'd0, dn}, 32'd0);
      do_req(1'b0, 1'b0, beats, dn, ena);
      check("R9 done each block", {31'd0, dn}, 32'd1);
      check("R9 stays live", {31'd0, ena}, 32'd1);
    end
    do_req(1'b1, 1'b0, beats, dn, ena);
    check("R9 reloaded size caps burst", beats, 2);
    pulse_dis();

    // R10 peripheral flow, first request is last
    setup(32'h700, 32'h800, 12'd0, 2'd0, 2'd0, 1'b0, 1'b1);
    pulse_en();
    check("R10 start with size 0", {31'd0, en_status}, 32'd1);
    do_req(1'b1, 1'b1, beats, dn, ena);
    check("R10 full burst", beats, 4);
    check("R10 done", {31'd0, dn}, 32'd1);
    check("R10 en cleared", {31'd0, ena}, 32'd0);
    // R10 last after non-last
    pulse_en();
    exp_src = 32'h700; exp_dst = 32'h800;
    do_req(1'b0, 1'b0, beats, dn, ena);
    check("R10 no done without last", {31'd0, dn}, 32'd0);
    do_req(1'b0, 1'b1, beats, dn, ena);
    check("R10 done with last", {31'd0, dn}, 32'd1);
    check("R10 en cleared second", {31'd0, ena}, 32'd0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule